// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block runs single programmed-I/O accesses from the host side of a parallel ATA bus. A local client hands it one request at a time: direction, a 3-bit register address, the two chip-select bits, 16-bit write data and a timing mode. The sequencer drives the address and chip selects, waits out the address setup, pulses the read or write strobe, and holds the bus after the strobe. It then idles the bus until both the recovery time and the whole-cycle minimum have passed, and reports completion with a one-cycle done pulse.

Every interval is a minimum number of clock cycles. Each interval is computed at elaboration from nanosecond limits and the clock period, rounded up to the next cycle. Accesses to the 16-bit data port use the short strobe. Every other register access is treated as 8-bit and, in modes 0 to 2, gets a much longer strobe. The device can stretch the strobe with IORDY, and a bounded wait ends a stuck access with an error flag. Mode codes above 4 fall back to the slowest timing.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset both strobes and both chip selects are high, the data bus is not driven, req_ready is high and done is low.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. From the next cycle ata_addr carries req_addr and ata_cs0_n/ata_cs1_n are low for req_cs0/req_cs1. The strobe goes low after S setup cycles, where S is 7, 5, 3, 3, 3 for modes 0 to 4 at 10 ns per cycle.
- R3: An access is 16-bit only when req_cs0=1, req_cs1=0 and req_addr=0. Its strobe lasts at least 17, 13, 10, 8, 7 cycles in modes 0 to 4. Any other access is 8-bit and its strobe lasts at least 29, 29, 29, 8, 7 cycles.
- R4: IORDY is sampled at the end of the 4th strobe cycle. If it is low there, the strobe stays low until the first edge at which IORDY is high, and never shorter than the R3 width.
- R5: IORDY going low only after the 4th strobe cycle has no effect, and the strobe ends at its R3 width.
- R6: If IORDY is still low 125 cycles after the sample point, the strobe is ended after 129 cycles in total and err is 1 with done. Otherwise err is 0. err holds its value until the next request is taken.
- R7: After the strobe rises, address, chip selects and write data are held for H cycles, with H = 3, 2, 2, 1, 1 for modes 0 to 4. The chip selects then rise.
- R8: done pulses for exactly one cycle, in the cycle after the busy interval. The busy interval is S + L + H + max(1, T0 - (S+L+H), R - H) cycles, where L is the actual strobe length, T0 is 60, 39, 24, 18, 12 and R is 0, 0, 0, 7, 3 for modes 0 to 4.
- R9: On a read, rdata is the ata_din value present at the clock edge that ends the strobe. rdata keeps that value through later writes until the next read.
- R10: A write drives ata_doe high with ata_dout equal to req_wdata from the first setup cycle to the last hold cycle. A read never drives ata_doe.
- R11: A req_mode value of 5, 6 or 7 gets mode 0 timing.
- R12: The read and write strobes are never low together. While a strobe is low, address and chip selects do not change, and at least one chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns period assumed by the default timing |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address within the selected block |
| req_cs0 | input | 1 | Select command block (active high) |
| req_cs1 | input | 1 | Select control block (active high) |
| req_wdata | input | 16 | Write data |
| req_mode | input | 3 | Timing mode, 0 to 4; 5 to 7 use mode 0 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| err | output | 1 | IORDY wait limit hit on the last access |
| ata_addr | output | 3 | Bus register address |
| ata_cs0_n | output | 1 | Command block select, active low |
| ata_cs1_n | output | 1 | Control block select, active low |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Data driven toward the device |
| ata_doe | output | 1 | Output enable for ata_dout |
| ata_din | input | 16 | Data returned by the device |
| ata_iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
The assertions check the bus-level invariants on every cycle. They cover exclusive strobes, address, chip selects and write data held steady under a strobe, no driving during a read, a single-cycle done, and a strobe that never runs past the IORDY limit. Only the bench's scenarios can show the exact cycle counts per mode and access width. The same holds for the 8-bit versus 16-bit choice, the fallback of out-of-range modes, where read data is captured, and how the strobe reacts to IORDY dropped before or after the sample point.

// File: rtl/ata_pio_pkg.sv
// Package: shared types and nanosecond timing limits for the PIO sequencer.
// Assumes mode codes 0..NUM_MODES-1 are valid; callers clamp anything else.
package ata_pio_pkg;

    localparam int NUM_MODES = 5;
    localparam int MODE_W    = 3;
    localparam int CNT_W     = 8;

    localparam int IORDY_SAMPLE_NS = 35;
    localparam int IORDY_LIMIT_NS  = 1250;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOV
    } state_t;

    // Per-access timing, all values in clock cycles
    typedef struct packed {
        cnt_t setup;
        cnt_t strobe;
        cnt_t hold;
        cnt_t recov;
        cnt_t cycle;
    } timing_t;

    function automatic int ns_to_cycles(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int at_least_one(int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cycle_ns(int m);
        case (m)
            1: return 383;
            2: return 240;
            3: return 180;
            4: return 120;
            default: return 600;
        endcase
    endfunction

    function automatic int setup_ns(int m);
        case (m)
            1: return 50;
            2: return 30;
            3: return 30;
            4: return 25;
            default: return 70;
        endcase
    endfunction

    function automatic int strobe16_ns(int m);
        case (m)
            1: return 125;
            2: return 100;
            3: return 80;
            4: return 70;
            default: return 165;
        endcase
    endfunction

    function automatic int strobe8_ns(int m);
        case (m)
            3: return 80;
            4: return 70;
            default: return 290;
        endcase
    endfunction

    function automatic int recov_ns(int m);
        case (m)
            3: return 70;
            4: return 25;
            default: return 0;
        endcase
    endfunction

    function automatic int wdata_hold_ns(int m);
        case (m)
            1: return 20;
            2: return 15;
            3: return 10;
            4: return 10;
            default: return 30;
        endcase
    endfunction

    function automatic int addr_hold_ns(int m);
        case (m)
            1: return 15;
            2: return 10;
            3: return 10;
            4: return 10;
            default: return 20;
        endcase
    endfunction

endpackage

// File: rtl/ata_pio_timing.sv
// Module: turns a mode code and access width into cycle counts.
// Every table entry is an elaboration-time constant; out-of-range mode
// codes are filled with the mode 0 row. Pure combinational lookup.
module ata_pio_timing
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              byte_acc,
    output timing_t           tmg
);

    localparam int ROWS = 2 ** MODE_W;

    timing_t wide_row   [ROWS];
    timing_t narrow_row [ROWS];

    // One table row per mode code, clamped to the slowest mode when invalid
    for (genvar m = 0; m < ROWS; m++) begin : g_row
        localparam int PM      = (m < NUM_MODES) ? m : 0;
        localparam int SETUP_C = at_least_one(ns_to_cycles(setup_ns(PM), CLK_NS));
        localparam int W16_C   = at_least_one(ns_to_cycles(strobe16_ns(PM), CLK_NS));
        localparam int W8_C    = at_least_one(ns_to_cycles(strobe8_ns(PM), CLK_NS));
        localparam int HOLD_C  = at_least_one(max2(ns_to_cycles(wdata_hold_ns(PM), CLK_NS),
                                                   ns_to_cycles(addr_hold_ns(PM), CLK_NS)));
        localparam int REC_C   = at_least_one(ns_to_cycles(recov_ns(PM), CLK_NS));
        localparam int CYC_C   = at_least_one(ns_to_cycles(cycle_ns(PM), CLK_NS));

        assign wide_row[m]   = '{setup: cnt_t'(SETUP_C), strobe: cnt_t'(W16_C),
                                 hold: cnt_t'(HOLD_C), recov: cnt_t'(REC_C),
                                 cycle: cnt_t'(CYC_C)};
        assign narrow_row[m] = '{setup: cnt_t'(SETUP_C), strobe: cnt_t'(W8_C),
                                 hold: cnt_t'(HOLD_C), recov: cnt_t'(REC_C),
                                 cycle: cnt_t'(CYC_C)};
    end

    // Pick the row for this access
    assign tmg = byte_acc ? narrow_row[mode] : wide_row[mode];

endmodule

// File: rtl/ata_pio_wait.sv
// Module: times the active strobe and applies IORDY stretching.
// IORDY is looked at first when the strobe has been low for the sample
// time; a low there starts a wait that ends on IORDY high or on the limit.
// Assumes strobe_min >= 1 and that strobe_on drops in the cycle after
// strobe_end.
module ata_pio_wait
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_on,
    input  cnt_t strobe_min,
    input  logic iordy,
    output logic strobe_end,
    output logic timed_out
);

    localparam int   SAMPLE_C    = at_least_one(ns_to_cycles(IORDY_SAMPLE_NS, CLK_NS));
    localparam int   LIMIT_C     = ns_to_cycles(IORDY_LIMIT_NS, CLK_NS);
    localparam cnt_t SAMPLE_IDX  = cnt_t'(SAMPLE_C - 1);
    localparam cnt_t TIMEOUT_IDX = cnt_t'(SAMPLE_C - 1 + LIMIT_C);

    cnt_t sc;
    logic wait_q;
    logic stalled;
    logic min_met;

    // Device is holding the cycle: low at the sample point, or still low in a wait
    assign stalled    = !iordy && ((sc == SAMPLE_IDX) || wait_q);
    assign min_met    = (sc >= strobe_min - cnt_t'(1)) && (sc >= SAMPLE_IDX);
    assign timed_out  = strobe_on && stalled && (sc >= TIMEOUT_IDX);
    assign strobe_end = strobe_on && ((min_met && !stalled) || timed_out);

    // Strobe cycle counter and wait flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc     <= '0;
            wait_q <= 1'b0;
        end else if (!strobe_on || strobe_end) begin
            sc     <= '0;
            wait_q <= 1'b0;
        end else begin
            if (sc != '1) sc <= sc + cnt_t'(1);
            wait_q <= stalled;
        end
    end

    assert_wait_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_on |-> (sc <= TIMEOUT_IDX));

    assert_strobe_drops_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_end |=> (sc == '0));

endmodule

// File: rtl/ata_pio_seq.sv
// Module: top of the host PIO cycle sequencer.
// Takes one request over a valid/ready port and runs setup, strobe,
// hold and recovery phases, each a minimum cycle count picked per access
// from the timing table. Read data is captured at the edge ending the
// strobe. Outputs are decoded from registered state; no tri-state here.
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cs0,
    input  logic              req_cs1,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MODE_W-1:0] req_mode,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic [DATA_W-1:0] ata_dout,
    output logic              ata_doe,
    input  logic [DATA_W-1:0] ata_din,
    input  logic              ata_iordy
);

    state_t            st;
    timing_t           tm;
    timing_t           req_tm;
    cnt_t              cnt;
    cnt_t              tc;
    cnt_t              rc;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic              cs0_q;
    logic              cs1_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              done_q;
    logic              byte_acc;
    logic              bus_busy;
    logic              strobe_on;
    logic              strobe_end;
    logic              timed_out;
    logic              accept;

    // Only the data port with the command block alone is a 16-bit access
    assign byte_acc = !(req_cs0 && !req_cs1 && (req_addr == '0));
    assign accept   = req_valid && (st == ST_IDLE);

    ata_pio_timing #(
        .CLK_NS (CLK_NS)
    ) u_timing (
        .mode     (req_mode),
        .byte_acc (byte_acc),
        .tmg      (req_tm)
    );

    ata_pio_wait #(
        .CLK_NS (CLK_NS)
    ) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_on  (strobe_on),
        .strobe_min (tm.strobe),
        .iordy      (ata_iordy),
        .strobe_end (strobe_end),
        .timed_out  (timed_out)
    );

    // Phase sequencing, counters and captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            tm      <= '0;
            cnt     <= '0;
            tc      <= '0;
            rc      <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            cs0_q   <= 1'b0;
            cs1_q   <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st != ST_IDLE && tc != '1) tc <= tc + cnt_t'(1);
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st      <= ST_SETUP;
                        tm      <= req_tm;
                        cnt     <= '0;
                        tc      <= '0;
                        wr_q    <= req_write;
                        addr_q  <= req_addr;
                        cs0_q   <= req_cs0;
                        cs1_q   <= req_cs1;
                        wdata_q <= req_wdata;
                        err_q   <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (cnt >= tm.setup - cnt_t'(1)) begin
                        st  <= ST_STROBE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
                ST_STROBE: begin
                    if (strobe_end) begin
                        st    <= ST_HOLD;
                        cnt   <= '0;
                        rc    <= '0;
                        err_q <= timed_out;
                        if (!wr_q) rdata_q <= ata_din;
                    end
                end
                ST_HOLD: begin
                    if (rc != '1) rc <= rc + cnt_t'(1);
                    if (cnt >= tm.hold - cnt_t'(1)) begin
                        st  <= ST_RECOV;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
                ST_RECOV: begin
                    if (rc != '1) rc <= rc + cnt_t'(1);
                    if ((tc >= tm.cycle - cnt_t'(1)) && (rc >= tm.recov - cnt_t'(1))) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Bus pin decode from the registered phase
    assign bus_busy  = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
    assign strobe_on = (st == ST_STROBE);
    assign req_ready = (st == ST_IDLE);
    assign ata_addr  = addr_q;
    assign ata_cs0_n = !(bus_busy && cs0_q);
    assign ata_cs1_n = !(bus_busy && cs1_q);
    assign ata_rd_n  = !(strobe_on && !wr_q);
    assign ata_wr_n  = !(strobe_on && wr_q);
    assign ata_doe   = bus_busy && wr_q;
    assign ata_dout  = wdata_q;
    assign done      = done_q;
    assign rdata     = rdata_q;
    assign err       = err_q;

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    assert_bus_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ata_rd_n || !ata_wr_n) && ($past(!ata_rd_n) || $past(!ata_wr_n)))
        |-> ($stable(ata_addr) && $stable(ata_cs0_n) && $stable(ata_cs1_n)));

    assert_strobe_has_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n) |-> (!ata_cs0_n || !ata_cs1_n));

    assert_no_drive_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_rd_n |-> !ata_doe);

    assert_wdata_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_doe && $past(ata_doe)) |-> $stable(ata_dout));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && ata_cs0_n && ata_cs1_n));

endmodule

// File: tb/ata_pio_seq_bench.sv
// Bench: sweeps every mode code, direction and register select, plus
// IORDY wait, late-low and timeout cases; expected cycle counts are
// computed from the nanosecond limits and a 10 ns clock.
module ata_pio_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [2:0]  req_addr;
    logic        req_cs0;
    logic        req_cs1;
    logic [15:0] req_wdata;
    logic [2:0]  req_mode;
    logic        done;
    logic [15:0] rdata;
    logic        err;
    logic [2:0]  ata_addr;
    logic        ata_cs0_n;
    logic        ata_cs1_n;
    logic        ata_rd_n;
    logic        ata_wr_n;
    logic [15:0] ata_dout;
    logic        ata_doe;
    logic [15:0] ata_din;
    logic        ata_iordy;

    int vectors = 0;
    int errors  = 0;
    logic [15:0] last_read = 16'h0000;

    always #5 clk = ~clk;

    ata_pio_seq u_ata_pio_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_cs0   (req_cs0),
        .req_cs1   (req_cs1),
        .req_wdata (req_wdata),
        .req_mode  (req_mode),
        .done      (done),
        .rdata     (rdata),
        .err       (err),
        .ata_addr  (ata_addr),
        .ata_cs0_n (ata_cs0_n),
        .ata_cs1_n (ata_cs1_n),
        .ata_rd_n  (ata_rd_n),
        .ata_wr_n  (ata_wr_n),
        .ata_dout  (ata_dout),
        .ata_doe   (ata_doe),
        .ata_din   (ata_din),
        .ata_iordy (ata_iordy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cyc(int ns);
        return (ns + 9) / 10;
    endfunction

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // One access. iordy_kind: 0 high, 1 low until strobe count hits rel (0 = never),
    // 2 high at the sample point then low from strobe count rel to strobe end
    task automatic run(input bit wr, input logic [2:0] a, input bit c0, input bit c1,
                       input logic [2:0] mode, input logic [15:0] wd,
                       input logic [15:0] rv, input int iordy_kind, input int rel);
        int cyc_ns[5] = '{600, 383, 240, 180, 120};
        int set_ns[5] = '{70, 50, 30, 30, 25};
        int s16_ns[5] = '{165, 125, 100, 80, 70};
        int s8_ns[5]  = '{290, 290, 290, 80, 70};
        int rec_ns[5] = '{0, 0, 0, 70, 25};
        int dh_ns[5]  = '{30, 20, 15, 10, 10};
        int ah_ns[5]  = '{20, 15, 10, 10, 10};
        int m, s, w, h, r, t0, l, total, samp, lim;
        bit bytew, exp_err;
        int first_str, str_cnt, last_cs, done_at, oe_cnt;
        bit bad_sel, bad_dout, bad_other, swapped;

        m     = (mode > 3'd4) ? 0 : int'(mode);
        bytew = !(c0 && !c1 && a == 3'd0);
        s     = mx(1, cyc(set_ns[m]));
        w     = mx(1, cyc(bytew ? s8_ns[m] : s16_ns[m]));
        h     = mx(1, mx(cyc(dh_ns[m]), cyc(ah_ns[m])));
        r     = cyc(rec_ns[m]);
        t0    = cyc(cyc_ns[m]);
        samp  = cyc(35);
        lim   = cyc(1250);
        exp_err = 1'b0;
        l = mx(w, samp);
        if (iordy_kind == 1) begin
            if (rel == 0) begin
                l = samp + lim;
                exp_err = 1'b1;
            end else begin
                l = mx(w, rel);
            end
        end
        total = s + l + h;
        total = total + mx(1, mx(t0 - total, r - h));

        @(negedge clk);
        check(req_ready == 1'b1, "R8", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_cs0   = c0;
        req_cs1   = c1;
        req_wdata = wd;
        req_mode  = mode;
        ata_din   = rv;
        ata_iordy = (iordy_kind == 1) ? 1'b0 : 1'b1;

        first_str = 0; str_cnt = 0; last_cs = 0; done_at = 0; oe_cnt = 0;
        bad_sel = 1'b0; bad_dout = 1'b0; bad_other = 1'b0; swapped = 1'b0;
        for (int k = 1; k <= total + 40; k++) begin
            bit str_now;
            @(negedge clk);
            if (k == 1) begin
                req_valid = 1'b0;
                req_wdata = ~wd;
            end
            str_now = wr ? !ata_wr_n : !ata_rd_n;
            if (wr ? !ata_rd_n : !ata_wr_n) bad_other = 1'b1;
            if (!ata_cs0_n || !ata_cs1_n) begin
                last_cs = k;
                if (ata_addr != a || ata_cs0_n != !c0 || ata_cs1_n != !c1) bad_sel = 1'b1;
            end
            if (k <= s + l + h && (ata_cs0_n == c0 ? 1'b0 : 1'b0)) bad_sel = 1'b1;
            if (k == 1 && (ata_addr != a || ata_cs0_n != !c0 || ata_cs1_n != !c1)) bad_sel = 1'b1;
            if (ata_doe) begin
                oe_cnt++;
                if (ata_dout != wd) bad_dout = 1'b1;
            end
            if (str_now) begin
                if (first_str == 0) first_str = k;
                str_cnt++;
            end
            if (iordy_kind == 1 && rel != 0 && str_cnt == rel) ata_iordy = 1'b1;
            if (iordy_kind == 2 && str_now && str_cnt == rel) ata_iordy = 1'b0;
            if (!str_now && str_cnt > 0) begin
                ata_iordy = 1'b1;
                if (!wr && !swapped) begin
                    ata_din = ~rv;
                    swapped = 1'b1;
                end
            end
            if (done) begin
                done_at = k;
                break;
            end
        end

        check(first_str == s + 1, "R2", "strobe start cycle", first_str, s + 1);
        check(!bad_sel, "R2", "address/select during access", int'(bad_sel), 0);
        check(str_cnt == l, (iordy_kind == 0) ? "R3" : (iordy_kind == 2) ? "R5" :
              (rel == 0) ? "R6" : "R4", "strobe length", str_cnt, l);
        check(last_cs == s + l + h, "R7", "last select cycle", last_cs, s + l + h);
        check(done_at == total + 1, "R8", "done cycle", done_at, total + 1);
        check(err == exp_err, "R6", "err flag", int'(err), int'(exp_err));
        check(!bad_other, "R12", "opposite strobe low", int'(bad_other), 0);
        if (wr) begin
            check(oe_cnt == s + l + h, "R10", "write drive cycles", oe_cnt, s + l + h);
            check(!bad_dout, "R10", "write data value", int'(bad_dout), 0);
            check(rdata == last_read, "R9", "rdata kept over write", int'(rdata), int'(last_read));
        end else begin
            check(oe_cnt == 0, "R10", "drive during read", oe_cnt, 0);
            check(rdata == rv, "R9", "captured read data", int'(rdata), int'(rv));
            last_read = rv;
        end
        if (mode > 3'd4)
            check(done_at == total + 1, "R11", "fallback mode timing", done_at, total + 1);
        ata_iordy = 1'b1;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = 3'd0;
        req_cs0   = 1'b0;
        req_cs1   = 1'b0;
        req_wdata = 16'h0000;
        req_mode  = 3'd0;
        ata_din   = 16'h0000;
        ata_iordy = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ata_rd_n && ata_wr_n, "R1", "strobes after reset", int'({ata_rd_n, ata_wr_n}), 3);
        check(ata_cs0_n && ata_cs1_n, "R1", "selects after reset", int'({ata_cs0_n, ata_cs1_n}), 3);
        check(!ata_doe, "R1", "drive after reset", int'(ata_doe), 0);
        check(req_ready && !done, "R1", "ready/done after reset", int'({req_ready, done}), 2);

        // Sweep: every mode code, both directions, all command registers and two control ones
        for (int md = 0; md < 8; md++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int sel = 0; sel < 10; sel++) begin
                    logic [2:0]  ad;
                    bit          c0, c1;
                    logic [15:0] wd, rv;
                    ad = (sel < 8) ? 3'(sel) : 3'(sel - 2);
                    c0 = (sel < 8);
                    c1 = (sel >= 8);
                    wd = 16'(md * 4099 + sel * 257 + wr * 31 + 16'h1234);
                    rv = 16'(md * 1543 + sel * 911 + 16'h0a5a);
                    run(wr[0], ad, c0, c1, 3'(md), wd, rv, 0, 0);
                end
            end
        end

        // R4: device stretches the strobe past its minimum width
        run(1'b0, 3'd2, 1'b1, 1'b0, 3'd0, 16'h0, 16'hbeef, 1, 50);
        run(1'b1, 3'd0, 1'b1, 1'b0, 3'd4, 16'h5a5a, 16'h0, 1, 20);
        // R4: wait released before the minimum width, minimum still applies
        run(1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 16'h0, 16'h1357, 1, 6);
        // R5: IORDY low after the sample point is ignored
        run(1'b0, 3'd0, 1'b1, 1'b0, 3'd4, 16'h0, 16'h2468, 2, 5);
        run(1'b1, 3'd3, 1'b1, 1'b0, 3'd3, 16'hc3c3, 16'h0, 2, 6);
        // R6: IORDY never returns, then a clean access clears err
        run(1'b0, 3'd0, 1'b1, 1'b0, 3'd4, 16'h0, 16'h7777, 1, 0);
        run(1'b1, 3'd6, 1'b0, 1'b1, 3'd0, 16'h00ff, 16'h0, 1, 0);
        run(1'b0, 3'd1, 1'b1, 1'b0, 3'd2, 16'h0, 16'h8421, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule